// File: doc/BRIEF.md
# Configurable 64-Source Interrupt Controller

This block collects up to 64 external request lines and presents one level interrupt towards a host processor. Each source is set up through two 32-bit configuration words on a small register bus. The first word holds the enable pair and the sense code. The second word holds the priority value and a stored class field. A status register returns the number of the source that currently wins arbitration. The code 63 is reserved to mean that nothing is pending.

Sources 47 through 50 can be set to capture edges. A captured edge stays pending until software clears it with a write to the edge-clear register. That write selects the source by the low four bits of its number. Every other source is treated as active-high level, whatever its sense code. There are three global controls. A detection gate blocks all reporting. An output gate blocks only the interrupt pin. A mask-level threshold hides sources whose priority value is at or above the threshold.

The output logic is a two-state machine. `ST_QUIET` moves to `ST_RAISED` on the RAISE transition, taken when a winner exists and the output gate is open. `ST_RAISED` returns to `ST_QUIET` on the DROP transition, taken when either condition is lost. The interrupt pin is high exactly in `ST_RAISED`.

Top module: `intc_top`

## Requirements
- R1: After reset every configuration word and control register reads 0, no edge is captured, status bits 31:24 read 63 and the interrupt output is low.
- R2: Source n's first configuration word is at byte offset 0x200+8n and its second at 0x204+8n; both read back the full 32-bit value last written.
- R3: A source takes part in arbitration only when bits 29 and 28 of its first word are both 1; either bit alone leaves it disabled.
- R4: For sources 47..50, bits 25:24 of the first word select 0 = active low level, 1 = active high level, 2 = falling edge, 3 = rising edge; all other sources are active-high level for every code.
- R5: A captured edge stays pending after the input returns idle, until a write to 0x0C0 with bit 8 set and bits 3:0 equal to the low four bits of the source number (15 for 47, 0/1/2 for 48/49/50); a write with bit 8 clear or another index leaves it pending.
- R6: Reading 0x144 returns the winning source number in bits 31:24 (other bits 0), or 63 when no source is pending; source 63 never wins and never raises the output.
- R7: The winner is the pending source with the smallest priority value (bits 7:0 of the second word); equal values go to the lower source number.
- R8: When bit 0 of 0x004 is 0, no source is pending, status reads 63 and the output is low.
- R9: The output asserts only while bit 0 of 0x444 is 1; clearing it drops the output without changing the status value.
- R10: The register at 0x084 (bits 7:0 as threshold) masks nothing when 0; when nonzero it hides every source whose priority value is greater than or equal to it.
- R11: Read data appears on the cycle after the read strobe; the status register and the output follow an input or register change within one further clock.
- R12: Edge-window inputs pass a two-flop synchroniser, so a rising request on an edge source raises the output four clocks after the input changes and not two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after the read strobe |
| irq_req | input | 64 | External request lines |
| irq_o | output | 1 | Level interrupt towards the host |

## Verification
The bench builds the block with its default parameters: 64 sources, 8-bit priorities, and an edge window of four sources starting at 47. These values make the reserved code 63 a real request line. They also make the edge window straddle a 16-source boundary, so the clear index wraps from 15 to 0 between sources 47 and 48. Both the wrap and the wrong-index case are checked, along with the synchroniser delay measured at the interrupt pin.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam logic [11:0] OFS_DETECT  = 12'h004;
    localparam logic [11:0] OFS_MASKLVL = 12'h084;
    localparam logic [11:0] OFS_EDGECLR = 12'h0C0;
    localparam logic [11:0] OFS_STATUS  = 12'h144;
    localparam logic [11:0] OFS_CFG     = 12'h200;
    localparam logic [11:0] OFS_OUTEN   = 12'h444;

    localparam int EN_HI_BIT   = 29;
    localparam int EN_LO_BIT   = 28;
    localparam int SENSE_LSB   = 24;
    localparam int CLR_GO_BIT  = 8;
    localparam int STATUS_LSB  = 24;

    typedef enum logic [1:0] {
        SENSE_LVL_LOW  = 2'd0,
        SENSE_LVL_HIGH = 2'd1,
        SENSE_FALL     = 2'd2,
        SENSE_RISE     = 2'd3
    } sense_e;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } out_state_e;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int NUM_SRC    = 64,
    parameter int PRIO_W     = 8,
    parameter int EDGE_FIRST = 47,
    parameter int EDGE_COUNT = 4,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                addr,
    input  logic                             wr_en,
    input  logic                             rd_en,
    input  logic [DATA_W-1:0]                wdata,
    output logic [DATA_W-1:0]                rdata,
    input  logic [$clog2(NUM_SRC)-1:0]       winner_i,
    output logic [NUM_SRC-1:0]               src_en_o,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_o,
    output logic [EDGE_COUNT-1:0][1:0]       sense_win_o,
    output logic [EDGE_COUNT-1:0]            clr_hit_o,
    output logic                             det_en_o,
    output logic                             out_en_o,
    output logic [PRIO_W-1:0]                mask_lvl_o
);
    localparam int SRC_W     = $clog2(NUM_SRC);
    localparam int CFG_BYTES = 8 * NUM_SRC;
    localparam int CFG_LO    = int'(OFS_CFG);
    localparam int CFG_HI    = CFG_LO + CFG_BYTES;

    logic [DATA_W-1:0] cfg_a [NUM_SRC];
    logic [DATA_W-1:0] cfg_b [NUM_SRC];
    logic [DATA_W-1:0] ctl_detect;
    logic [DATA_W-1:0] ctl_mask;
    logic [DATA_W-1:0] ctl_outen;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_mux;
    logic              cfg_sel;
    logic [SRC_W-1:0]  cfg_idx;

    // The configuration window is aligned to its own size, so the slot
    // number is a plain slice of the address.
    assign cfg_sel = (int'(addr) >= CFG_LO) && (int'(addr) < CFG_HI);
    assign cfg_idx = addr[SRC_W+2:3];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                cfg_a[i] <= '0;
                cfg_b[i] <= '0;
            end
            ctl_detect <= '0;
            ctl_mask   <= '0;
            ctl_outen  <= '0;
            rdata_q    <= '0;
        end else begin
            if (wr_en) begin
                if (cfg_sel) begin
                    if (addr[2]) cfg_b[cfg_idx] <= wdata;
                    else         cfg_a[cfg_idx] <= wdata;
                end else if (addr == OFS_DETECT) begin
                    ctl_detect <= wdata;
                end else if (addr == OFS_MASKLVL) begin
                    ctl_mask <= wdata;
                end else if (addr == OFS_OUTEN) begin
                    ctl_outen <= wdata;
                end
            end
            rdata_q <= rd_en ? rd_mux : '0;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (cfg_sel) begin
            rd_mux = addr[2] ? cfg_b[cfg_idx] : cfg_a[cfg_idx];
        end else if (addr == OFS_DETECT) begin
            rd_mux = ctl_detect;
        end else if (addr == OFS_MASKLVL) begin
            rd_mux = ctl_mask;
        end else if (addr == OFS_OUTEN) begin
            rd_mux = ctl_outen;
        end else if (addr == OFS_STATUS) begin
            rd_mux[STATUS_LSB +: 8] = 8'(winner_i);
        end
    end

    assign rdata      = rdata_q;
    assign det_en_o   = ctl_detect[0];
    assign out_en_o   = ctl_outen[0];
    assign mask_lvl_o = ctl_mask[PRIO_W-1:0];

    genvar n;
    generate
        for (n = 0; n < NUM_SRC; n++) begin : g_fields
            assign src_en_o[n] = cfg_a[n][EN_HI_BIT] & cfg_a[n][EN_LO_BIT];
            assign prio_o[n]   = cfg_b[n][PRIO_W-1:0];
        end
        for (n = 0; n < EDGE_COUNT; n++) begin : g_window
            assign sense_win_o[n] = cfg_a[EDGE_FIRST+n][SENSE_LSB +: 2];
            assign clr_hit_o[n]   = wr_en && (addr == OFS_EDGECLR)
                                    && wdata[CLR_GO_BIT]
                                    && (wdata[3:0] == 4'((EDGE_FIRST + n) % 16));
        end
    endgenerate
endmodule

// File: rtl/intc_sense.sv
module intc_sense
    import intc_pkg::*;
#(
    parameter int EDGE_COUNT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [EDGE_COUNT-1:0]      req_i,
    input  logic [EDGE_COUNT-1:0][1:0] sense_i,
    input  logic [EDGE_COUNT-1:0]      clr_hit_i,
    input  logic                       det_en_i,
    output logic [EDGE_COUNT-1:0]      active_o
);
    genvar k;
    generate
        for (k = 0; k < EDGE_COUNT; k++) begin : g_src
            logic [2:0] shift_q;     // [0],[1] synchroniser, [2] history
            logic       held_q;
            logic       rise;
            logic       fall;
            logic       edge_mode;
            logic       seen;
            sense_e     code;

            assign code      = sense_e'(sense_i[k]);
            assign rise      = shift_q[1] & ~shift_q[2];
            assign fall      = ~shift_q[1] & shift_q[2];
            assign edge_mode = sense_i[k][1];
            assign seen      = (code == SENSE_RISE) ? rise : fall;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    shift_q <= '0;
                    held_q  <= 1'b0;
                end else begin
                    shift_q <= {shift_q[1:0], req_i[k]};
                    if (edge_mode && det_en_i && seen) begin
                        held_q <= 1'b1;
                    end else if (clr_hit_i[k] || !edge_mode) begin
                        held_q <= 1'b0;
                    end
                end
            end

            always_comb begin
                unique case (code)
                    SENSE_LVL_LOW:  active_o[k] = ~shift_q[1];
                    SENSE_LVL_HIGH: active_o[k] = shift_q[1];
                    default:        active_o[k] = held_q;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 8
) (
    input  logic [NUM_SRC-1:0]             active_i,
    input  logic [NUM_SRC-1:0]             src_en_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic                           det_en_i,
    input  logic [PRIO_W-1:0]              mask_lvl_i,
    output logic [NUM_SRC-1:0]             pend_o,
    output logic [$clog2(NUM_SRC)-1:0]     win_idx_o,
    output logic                           win_any_o
);
    localparam int SRC_W    = $clog2(NUM_SRC);
    localparam int NONE_IDX = NUM_SRC - 1;

    genvar n;
    generate
        for (n = 0; n < NUM_SRC; n++) begin : g_pend
            logic below;
            assign below     = (mask_lvl_i == '0) || (prio_i[n] < mask_lvl_i);
            assign pend_o[n] = active_i[n] & src_en_i[n] & det_en_i & below
                               & (n != NONE_IDX);
        end
    endgenerate

    // Strict less-than keeps the earlier (lower-numbered) source on ties.
    always_comb begin
        logic [PRIO_W-1:0] best_p;
        best_p    = '1;
        win_any_o = 1'b0;
        win_idx_o = SRC_W'(NONE_IDX);
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend_o[i] && (!win_any_o || (prio_i[i] < best_p))) begin
                win_any_o = 1'b1;
                best_p    = prio_i[i];
                win_idx_o = SRC_W'(i);
            end
        end
    end
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int NUM_SRC    = 64,
    parameter int PRIO_W     = 8,
    parameter int EDGE_FIRST = 47,
    parameter int EDGE_COUNT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [11:0]        bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] irq_req,
    output logic               irq_o
);
    localparam int SRC_W    = $clog2(NUM_SRC);
    localparam int NONE_IDX = NUM_SRC - 1;

    logic [NUM_SRC-1:0]             src_en;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    logic [EDGE_COUNT-1:0][1:0]     sense_win;
    logic [EDGE_COUNT-1:0]          clr_hit;
    logic [EDGE_COUNT-1:0]          active_win;
    logic [NUM_SRC-1:0]             active;
    logic [NUM_SRC-1:0]             pend;
    logic                           det_en;
    logic                           out_en;
    logic [PRIO_W-1:0]              mask_lvl;
    logic [SRC_W-1:0]               win_idx;
    logic                           win_any;
    logic [SRC_W-1:0]               winner_q;
    out_state_e                     state_q;
    out_state_e                     state_d;

    intc_regs #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W),
        .EDGE_FIRST(EDGE_FIRST), .EDGE_COUNT(EDGE_COUNT),
        .DATA_W(32), .ADDR_W(12)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .addr(bus_addr), .wr_en(bus_wr), .rd_en(bus_rd),
        .wdata(bus_wdata), .rdata(bus_rdata),
        .winner_i(winner_q),
        .src_en_o(src_en), .prio_o(prio),
        .sense_win_o(sense_win), .clr_hit_o(clr_hit),
        .det_en_o(det_en), .out_en_o(out_en), .mask_lvl_o(mask_lvl)
    );

    intc_sense #(.EDGE_COUNT(EDGE_COUNT)) u_sense (
        .clk(clk), .rst_n(rst_n),
        .req_i(irq_req[EDGE_FIRST +: EDGE_COUNT]),
        .sense_i(sense_win), .clr_hit_i(clr_hit),
        .det_en_i(det_en), .active_o(active_win)
    );

    genvar n;
    generate
        for (n = 0; n < NUM_SRC; n++) begin : g_act
            if (n >= EDGE_FIRST && n < EDGE_FIRST + EDGE_COUNT) begin : g_win
                assign active[n] = active_win[n - EDGE_FIRST];
            end else begin : g_lvl
                assign active[n] = irq_req[n];
            end
        end
    endgenerate

    intc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
        .active_i(active), .src_en_i(src_en), .prio_i(prio),
        .det_en_i(det_en), .mask_lvl_i(mask_lvl),
        .pend_o(pend), .win_idx_o(win_idx), .win_any_o(win_any)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) winner_q <= SRC_W'(NONE_IDX);
        else        winner_q <= win_idx;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    // Transitions: RAISE and DROP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (win_any && out_en)    state_d = ST_RAISED;
            ST_RAISED: if (!(win_any && out_en)) state_d = ST_QUIET;
            default:                             state_d = ST_QUIET;
        endcase
    end

    // Outputs
    always_comb begin
        irq_o = (state_q == ST_RAISED);
    end
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
    parameter int NUM_SRC = 64
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       irq,
    input logic [$clog2(NUM_SRC)-1:0] winner,
    input logic                       det_en,
    input logic                       out_en,
    input logic [NUM_SRC-1:0]         pend
);
    localparam int SRC_W = $clog2(NUM_SRC);
    localparam logic [SRC_W-1:0] NONE = SRC_W'(NUM_SRC - 1);

    logic [NUM_SRC-1:0] pend_q;
    always_ff @(posedge clk) pend_q <= pend;

    a_r9_irq_needs_outen: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(out_en));

    a_r6_irq_has_winner: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (winner != NONE));

    a_r8_detect_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(det_en) |-> (winner == NONE));

    a_r7_winner_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (winner != NONE) |-> pend_q[winner]);
endmodule

bind intc_top intc_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq_o), .winner(winner_q),
    .det_en(det_en), .out_en(out_en), .pend(pend)
);

// File: tb/tb_intc_top.sv
module tb_intc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_req = '0;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    intc_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .irq_o(irq_o)
    );

    function automatic logic [11:0] cfg_a(input int n); return 12'(12'h200 + 8*n); endfunction
    function automatic logic [11:0] cfg_b(input int n); return 12'(12'h204 + 8*n); endfunction
    function automatic logic [31:0] stat(input int n); return 32'(n) << 24; endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    // Driver side of the scoreboard
    task automatic rd_exp(input logic [11:0] a, input logic [31:0] e, input string t);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic irq_now(input logic e, input string t);
        chk({31'b0, irq_o}, {31'b0, e}, t);
    endtask

    // Monitor side of the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        irq_now(1'b0, "R1 irq after reset");
        rd_exp(12'h144, stat(63), "R1 status after reset");
        rd_exp(cfg_a(10), 32'h0, "R1 cfg word zero");
        rd_exp(12'h084, 32'h0, "R1 mask level zero");

        wr(12'h004, 32'h1);
        wr(12'h444, 32'h1);

        // R2 addressing and readback
        wr(cfg_b(5), 32'h0002_000A);
        rd_exp(cfg_b(5), 32'h0002_000A, "R2 second word readback");
        wr(cfg_a(5), 32'h1100_0000);
        rd_exp(cfg_a(5), 32'h1100_0000, "R2 first word readback");

        // R3 single enable bit is not enough
        irq_req[5] = 1'b1;
        settle();
        rd_exp(12'h144, stat(63), "R3 one enable bit");
        wr(cfg_a(5), 32'h3100_0000);
        settle();
        rd_exp(12'h144, stat(5), "R3 both enable bits");
        irq_now(1'b1, "R11 irq raised");

        // R7 priority and tie
        wr(cfg_b(9), 32'h3);
        wr(cfg_a(9), 32'h3000_0000);
        irq_req[9] = 1'b1;
        settle();
        rd_exp(12'h144, stat(9), "R7 lower value wins");
        wr(cfg_b(9), 32'hA);
        settle();
        rd_exp(12'h144, stat(5), "R7 tie to lower number");

        // R4 non-window source ignores code 0
        wr(cfg_a(5), 32'h0100_0000);
        irq_req[9] = 1'b0;
        settle();
        rd_exp(12'h144, stat(63), "R4 code 0 outside window, low input");
        irq_req[9] = 1'b1;
        settle();
        rd_exp(12'h144, stat(9), "R4 code 0 outside window, high input");

        // R10 mask level
        wr(12'h084, 32'hA);
        settle();
        rd_exp(12'h144, stat(63), "R10 threshold equal hides");
        wr(12'h084, 32'hB);
        settle();
        rd_exp(12'h144, stat(9), "R10 threshold above passes");
        wr(12'h084, 32'h0);

        // R9 output gate
        wr(12'h444, 32'h0);
        settle();
        irq_now(1'b0, "R9 output gated");
        rd_exp(12'h144, stat(9), "R9 status kept");
        wr(12'h444, 32'h1);
        settle();
        irq_now(1'b1, "R9 output reopened");

        // R8 detection gate
        wr(12'h004, 32'h0);
        settle();
        rd_exp(12'h144, stat(63), "R8 detect off status");
        irq_now(1'b0, "R8 detect off irq");
        wr(12'h004, 32'h1);
        irq_req[9] = 1'b0;

        // R6 reserved source
        wr(cfg_a(63), 32'h3100_0000);
        irq_req[63] = 1'b1;
        settle();
        rd_exp(12'h144, stat(63), "R6 source 63 never wins");
        irq_now(1'b0, "R6 source 63 no irq");
        irq_req[63] = 1'b0;

        // R12 and R5 rising edge on 48
        wr(cfg_b(48), 32'h1);
        wr(cfg_a(48), 32'h3300_0000);
        settle();
        @(negedge clk); irq_req[48] = 1'b1;
        repeat (2) @(negedge clk);
        irq_now(1'b0, "R12 synchroniser delay");
        repeat (2) @(negedge clk);
        irq_now(1'b1, "R12 edge reaches output");
        irq_req[48] = 1'b0;
        settle();
        rd_exp(12'h144, stat(48), "R5 edge held after input idle");
        wr(12'h0C0, 32'h0000_0000);
        settle();
        rd_exp(12'h144, stat(48), "R5 clear without go bit");
        wr(12'h0C0, 32'h0000_0100);
        settle();
        rd_exp(12'h144, stat(63), "R5 clear index 0 for 48");

        // R4 and R5 falling edge on 47
        irq_req[47] = 1'b1;
        settle();
        wr(cfg_b(47), 32'h1);
        wr(cfg_a(47), 32'h3200_0000);
        settle();
        rd_exp(12'h144, stat(63), "R4 falling mode ignores high level");
        irq_req[47] = 1'b0;
        settle();
        rd_exp(12'h144, stat(47), "R4 falling edge captured");
        wr(12'h0C0, 32'h0000_0101);
        settle();
        rd_exp(12'h144, stat(47), "R5 wrong index keeps edge");
        wr(12'h0C0, 32'h0000_010F);
        settle();
        rd_exp(12'h144, stat(63), "R5 clear index 15 for 47");

        // R4 level low and high on 50
        wr(cfg_b(50), 32'h1);
        wr(cfg_a(50), 32'h3000_0000);
        settle();
        rd_exp(12'h144, stat(50), "R4 level low active");
        irq_req[50] = 1'b1;
        settle();
        rd_exp(12'h144, stat(63), "R4 level low idle");
        wr(cfg_a(50), 32'h3100_0000);
        settle();
        rd_exp(12'h144, stat(50), "R4 level high in window");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule